// File: doc/BRIEF.md
# Predicated After-Last-Active Element Extractor

This block takes a wide vector operand and a byte-granular predicate mask and returns one element of the vector as a 64-bit scalar. It finds the highest-numbered element whose predicate is set. In the default mode it returns the element just above that one. If that element is the top lane of the vector, the selection wraps around to lane zero. A mode input makes it return the highest active element itself instead. When no element is active in either mode, the block passes through the low element-width bits of a fallback scalar operand, zero-extended.

Element width is chosen per request by a 2-bit code, so one instance serves byte, halfword, word and doubleword lanes. The vector width is a parameter. The result is registered. A request presented with `in_valid` produces `out_valid` and `result_o` one clock later. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `pred_elem_extract`

## Requirements
- R1: The element-size code `esize_i` selects width w = 8 << code (0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64 bits). Element i occupies vector bits [i*w +: w], and the vector holds VL/w elements.
- R2: Element i is active when predicate bit i*(w/8), the bit at its lowest byte, is set. All other predicate bits inside the element have no effect.
- R3: With `at_last_i` = 0 and at least one active element, the result is the element whose index is one above the highest active index.
- R4: With `at_last_i` = 0, if the highest active element is the final element (index VL/w - 1), the result is element 0.
- R5: With `at_last_i` = 1 and at least one active element, the result is the highest active element itself.
- R6: With no active element, the result is the low w bits of `fallback_i`, in either mode.
- R7: Result bits at position w and above are always zero.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `result_o` changes only in the cycle after `in_valid` and otherwise holds its value.
- R9: While `rst_n` is low, `out_valid` and `result_o` are zero. This holds immediately when reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| vec_i | input | VL | Vector operand |
| pred_i | input | VL/8 | Predicate, one bit per vector byte |
| esize_i | input | 2 | Element-size code |
| fallback_i | input | 64 | Scalar returned when no element is active |
| at_last_i | input | 1 | 1 returns the last active element, 0 returns the one after it |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Zero-extended selected element |

## Verification
The hardest cases to reach from the ports are masks whose only set bits lie inside elements rather than on their lowest byte. Such a mask is non-zero but counts as empty, so the fallback path must be taken. Wide elements paired with a predicate set only on the final lane are also hard to reach, because they exercise the wrap to lane zero. Fixed table rows place predicate bits at exactly those positions for each element size. Randomly sparse masks, built by ANDing several random words, then leave only a few active lanes so that the highest active index moves across the whole vector.

// File: rtl/pee_pkg.sv
package pee_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned SCALAR_W = 64;
  localparam int unsigned NUM_ESZ  = 4;

endpackage

// File: rtl/pee_lane_active.sv
module pee_lane_active
  import pee_pkg::*;
#(
  parameter int unsigned PL = 32
) (
  input  esz_e          esz,
  input  logic [PL-1:0] pred,
  output logic [PL-1:0] act
);

  logic [PL-1:0] per_sz [NUM_ESZ];

  for (genvar s = 0; s < NUM_ESZ; s++) begin : g_sz
    localparam int unsigned STEP = 1 << s;
    localparam int unsigned NEL  = PL / STEP;
    for (genvar e = 0; e < PL; e++) begin : g_el
      if (e < NEL) begin : g_live
        assign per_sz[s][e] = pred[e*STEP];
      end else begin : g_dead
        assign per_sz[s][e] = 1'b0;
      end
    end
  end

  always_comb begin
    act = per_sz[esz];
  end

endmodule

// File: rtl/pee_last_finder.sv
module pee_last_finder #(
  parameter int unsigned PL = 32,
  localparam int unsigned IW = $clog2(PL)
) (
  input  logic [PL-1:0] act,
  output logic          any,
  output logic [IW-1:0] last
);

  always_comb begin
    any  = 1'b0;
    last = '0;
    for (int i = 0; i < PL; i++) begin
      if (act[i]) begin
        any  = 1'b1;
        last = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pee_elem_select.sv
module pee_elem_select
  import pee_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned PL = VL / 8,
  localparam int unsigned IW = $clog2(PL)
) (
  input  logic [VL-1:0]       vec,
  input  esz_e                esz,
  input  logic [IW-1:0]       idx,
  output logic [SCALAR_W-1:0] elem
);

  logic [IW-1:0]   byte_off;
  logic [IW+2:0]   bit_off;
  logic [VL-1:0]   shifted;

  always_comb begin
    byte_off = idx << esz;
    bit_off  = {byte_off, 3'b000};
    shifted  = vec >> bit_off;
    unique case (esz)
      ESZ_8:   elem = {56'd0, shifted[7:0]};
      ESZ_16:  elem = {48'd0, shifted[15:0]};
      ESZ_32:  elem = {32'd0, shifted[31:0]};
      default: elem = shifted[63:0];
    endcase
  end

endmodule

// File: rtl/pred_elem_extract.sv
module pred_elem_extract
  import pee_pkg::*;
#(
  parameter int unsigned VL = 256,
  localparam int unsigned PL = VL / 8,
  localparam int unsigned IW = $clog2(PL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VL-1:0]       vec_i,
  input  logic [PL-1:0]       pred_i,
  input  logic [1:0]          esize_i,
  input  logic [63:0]         fallback_i,
  input  logic                at_last_i,
  output logic                out_valid,
  output logic [63:0]         result_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  esz_e          esz;
  logic [PL-1:0] act;
  logic          any;
  logic [IW-1:0] last;
  logic [IW:0]   n_elem;
  logic [IW:0]   last_p1;
  logic [IW-1:0] sel_idx;
  logic [63:0]   elem;
  logic [63:0]   fb_masked;

  assign esz = esz_e'(esize_i);

  pee_lane_active #(.PL(PL)) u_act (
    .esz  (esz),
    .pred (pred_i),
    .act  (act)
  );

  pee_last_finder #(.PL(PL)) u_last (
    .act  (act),
    .any  (any),
    .last (last)
  );

  // index of the chosen lane: at-last, or next with wrap
  always_comb begin
    n_elem  = (IW+1)'(PL) >> esz;
    last_p1 = {1'b0, last} + 1'b1;
    if (at_last_i)              sel_idx = last;
    else if (last_p1 == n_elem) sel_idx = '0;
    else                        sel_idx = last_p1[IW-1:0];
  end

  pee_elem_select #(.VL(VL)) u_sel (
    .vec  (vec_i),
    .esz  (esz),
    .idx  (sel_idx),
    .elem (elem)
  );

  always_comb begin
    unique case (esz)
      ESZ_8:   fb_masked = {56'd0, fallback_i[7:0]};
      ESZ_16:  fb_masked = {48'd0, fallback_i[15:0]};
      ESZ_32:  fb_masked = {32'd0, fallback_i[31:0]};
      default: fb_masked = fallback_i;
    endcase
  end

  // next state
  logic        valid_d;
  logic        res_en;
  logic [63:0] result_d;

  always_comb begin
    valid_d  = in_valid;
    res_en   = in_valid;
    result_d = any ? elem : fb_masked;
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) out_valid <= 1'b0;
    else         out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     result_o <= '0;
    else if (res_en) result_o <= result_d;
  end

  // assertions
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!arst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    !in_valid |=> $stable(result_o)); // R8
  AST_LAST_IS_HIGHEST: assert property (@(posedge clk) disable iff (!arst_n)
    any |-> ((act >> last) == PL'(1))); // R2
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    any |-> ({1'b0, sel_idx} < n_elem)); // R4
  AST_FALLBACK_WIDE: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && pred_i == '0 && esize_i == 2'd3) |=> result_o == $past(fallback_i)); // R6
  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!arst_n)
    (in_valid && esize_i == 2'd0) |=> result_o[63:8] == 56'd0); // R7

endmodule

// File: tb/pred_elem_extract_bench.sv
module pred_elem_extract_bench;

  localparam int unsigned VL = 256;
  localparam int unsigned PL = VL / 8;

  typedef struct packed {
    logic [1:0]    es;
    logic          mode;
    logic [PL-1:0] pred;
    logic [63:0]   fb;
    logic [3:0]    req;
  } row_t;

  // columns: size code, at_last, predicate, fallback, requirement
  localparam int NROWS = 12;
  localparam row_t TBL [NROWS] = '{
    '{2'd0, 1'b0, 32'h0000_0000, 64'h1122_3344_5566_77A5, 4'd6},  // R6 empty, byte
    '{2'd0, 1'b0, 32'h8000_0000, 64'h0,                   4'd4},  // R4 final byte lane wraps
    '{2'd0, 1'b0, 32'h0000_0001, 64'h0,                   4'd3},  // R3 only lane 0 -> lane 1
    '{2'd0, 1'b1, 32'h0001_0101, 64'h0,                   4'd5},  // R5 last active = 16
    '{2'd1, 1'b0, 32'h4000_0000, 64'h0,                   4'd4},  // R4 final half lane wraps
    '{2'd1, 1'b0, 32'hAAAA_AAAA, 64'hFFFF_EEEE_DDDD_CCCC, 4'd2},  // R2 only non-low bits -> empty
    '{2'd2, 1'b0, 32'h0000_00F0, 64'h0,                   4'd3},  // R3 word 1 -> word 2
    '{2'd2, 1'b1, 32'h0000_0000, 64'h8765_4321_0FED_CBA9, 4'd6},  // R6 empty in at-last mode
    '{2'd3, 1'b0, 32'h0100_0000, 64'h0,                   4'd4},  // R4 final dword wraps
    '{2'd3, 1'b1, 32'h0100_0000, 64'h0,                   4'd5},  // R5 final dword itself
    '{2'd3, 1'b0, 32'h0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 4'd6},  // R6 empty, full width
    '{2'd3, 1'b0, 32'hFEFE_FEFE, 64'h0123_4567_89AB_CDEF, 4'd2}   // R2 low byte clear -> empty
  };

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [VL-1:0]  vec_i;
  logic [PL-1:0]  pred_i;
  logic [1:0]     esize_i;
  logic [63:0]    fallback_i;
  logic           at_last_i;
  logic           out_valid;
  logic [63:0]    result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  pred_elem_extract #(.VL(VL)) u_pred_elem_extract (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .vec_i      (vec_i),
    .pred_i     (pred_i),
    .esize_i    (esize_i),
    .fallback_i (fallback_i),
    .at_last_i  (at_last_i),
    .out_valid  (out_valid),
    .result_o   (result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] wmask(input logic [1:0] es);
    int w = 8 << es;
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] model(input logic [VL-1:0] v, input logic [PL-1:0] p,
                                        input logic [1:0] es, input logic md,
                                        input logic [63:0] fb);
    int w = 8 << es;
    int n = VL / w;
    int lst = -1;
    int idx;
    for (int i = 0; i < n; i++) if (p[i*(w/8)]) lst = i;
    if (lst < 0) return fb & wmask(es);
    idx = md ? lst : ((lst + 1 == n) ? 0 : lst + 1);
    return 64'(v >> (idx * w)) & wmask(es);
  endfunction

  task automatic check(input int req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] es, input logic md, input logic [PL-1:0] p,
                       input logic [63:0] fb);
    @(negedge clk);
    esize_i    = es;
    at_last_i  = md;
    pred_i     = p;
    fallback_i = fb;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold;
    for (int j = 0; j < PL; j++) vec_i[j*8 +: 8] = 8'(j * 37 + 11);
    rst_n = 1'b0; in_valid = 1'b0; pred_i = '0; esize_i = '0;
    fallback_i = '0; at_last_i = 1'b0;
    repeat (3) @(negedge clk);
    check(9, "reset out_valid", 64'(out_valid), 64'd0);   // R9
    check(9, "reset result", result_o, 64'd0);            // R9
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NROWS; k++) begin
      apply(TBL[k].es, TBL[k].mode, TBL[k].pred, TBL[k].fb);
      check(8, "table out_valid", 64'(out_valid), 64'd1);
      check(int'(TBL[k].req), $sformatf("table row %0d", k), result_o,
            model(vec_i, TBL[k].pred, TBL[k].es, TBL[k].mode, TBL[k].fb));
    end

    // R8: idle cycle with changed inputs keeps the result
    hold = result_o;
    pred_i = 32'h0000_0001; esize_i = 2'd0; fallback_i = 64'h55;
    @(negedge clk);
    check(8, "idle out_valid", 64'(out_valid), 64'd0);
    check(8, "idle hold", result_o, hold);

    // R1: every lane position of each size via single-bit predicates
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < (PL >> s); e++) begin
        apply(2'(s), 1'b1, PL'(1) << (e << s), 64'h0);
        check(1, $sformatf("size %0d lane %0d", s, e), result_o,
              model(vec_i, PL'(1) << (e << s), 2'(s), 1'b1, 64'h0));
      end
    end

    // R3 R5 R7: random sparse masks, all sizes, both modes
    for (int r = 0; r < 300; r++) begin
      logic [1:0] es = 2'($urandom_range(0, 3));
      logic md = 1'($urandom_range(0, 1));
      logic [PL-1:0] p = PL'($urandom & $urandom & $urandom);
      logic [63:0] fb = {$urandom, $urandom};
      apply(es, md, p, fb);
      check(md ? 5 : 3, "random", result_o, model(vec_i, p, es, md, fb));
      check(7, "random upper bits", result_o & ~wmask(es), 64'd0);
    end

    // R9: asynchronous reset during operation
    apply(2'd3, 1'b1, 32'h0000_0001, 64'h0);
    #1 rst_n = 1'b0;
    #1;
    check(9, "async reset result", result_o, 64'd0);
    check(9, "async reset out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule